// File: doc/BRIEF.md
# Dual-Rate Clock Strobe Divider

This block divides a fast reference clock into two slower rates, a core rate and a system rate. Each rate is a single-cycle enable strobe in the fast clock domain. Peripheral logic qualifies its registers with the system strobe, and core logic uses the core strobe. The block also drives an external clock-out signal that follows the system rate and has its own enable bit.

The system ratio is linear: any value from 1 to 15. The core ratio is a power of two, selected by a 2-bit code. Software changes either ratio through a small register port while the block keeps running. A written value first goes into a shadow register. The divider loads it only when the period in progress ends, so no period is ever cut short. The block rejects a system select of zero: it keeps the previous ratio and sets a sticky error flag.

Top module: `ratio_strobe_gen`

## Requirements
- R1: After reset the applied system select is 5, the core select is 00, the clock-out enable is 1 and the error flag is 0. Both counters start at zero, so the core strobe is high at once. The first system strobe appears four clock edges after reset is released.
- R2: With system select N (1 to 15), the system strobe is high for one fast cycle in every N fast cycles.
- R3: The core select is the 2-bit field at bits 5:4 of register 0. It is coded 00 for divide by 1, 01 for divide by 2, 10 for divide by 4 and 11 for divide by 8, and the core strobe repeats at that period.
- R4: A ratio written in the middle of a period does not change that period. The next period uses the new ratio, and no shorter period appears in between.
- R5: Reading register 0 (address 0) returns the applied ratios: the system select in bits 3:0, the core select in bits 5:4, and zero in the other bits.
- R6: A write to register 0 whose bits 3:0 are zero leaves the system ratio unchanged and sets the error flag. The core field of the same write is still accepted.
- R7: Register 1 bit 0 enables the clock-out signal. While enabled, the signal toggles on every system strobe, so it stays high for N cycles and low for N cycles. While disabled, it is held low.
- R8: Reading register 1 returns the clock-out enable in bit 0 and the error flag in bit 1.
- R9: Once set, the error flag stays set through later writes and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 ratios, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register selected by reg_addr |
| sys_stb | output | 1 | System-rate enable strobe |
| core_stb | output | 1 | Core-rate enable strobe |
| clkout | output | 1 | Gated external clock-out at half the system strobe rate |
| cfg_err | output | 1 | Sticky flag for a rejected zero system select |

## Verification
The bench builds the block with its default parameters: a 4-bit linear system select, a 2-bit power-of-two core select and a reset system select of 5. With these widths, the slowest system period (15 cycles) and the slowest core period (8 cycles) take only tens of cycles to measure. This puts the extreme ratios, mid-period reprogramming of both dividers, and the zero-select rejection within reach of short directed runs. Periods are measured as the gaps between strobes and as the run lengths of the clock-out signal.

// File: rtl/ratio_pkg.sv
package ratio_pkg;

    localparam int SYS_SEL_W  = 4;
    localparam int CORE_SEL_W = 2;
    localparam int REG_DATA_W = 8;

    typedef enum logic {
        DIV_LINEAR = 1'b0,
        DIV_POW2   = 1'b1
    } div_mode_e;

    typedef enum logic {
        ADDR_RATIO = 1'b0,
        ADDR_CTRL  = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic err;
        logic out_en;
    } ctrl_state_t;

    // Division ratio for a select code under a given encoding.
    function automatic int unsigned div_ratio(div_mode_e mode, int unsigned sel);
        if (mode == DIV_LINEAR) begin
            return sel;
        end
        return 32'd1 << sel;
    endfunction

    // Largest ratio a select field of the given width can express.
    function automatic int unsigned max_ratio(div_mode_e mode, int unsigned sel_w);
        if (mode == DIV_LINEAR) begin
            return (32'd1 << sel_w) - 32'd1;
        end
        return 32'd1 << ((32'd1 << sel_w) - 32'd1);
    endfunction

endpackage

// File: rtl/ratio_counter.sv
module ratio_counter
    import ratio_pkg::*;
#(
    parameter div_mode_e        MODE    = DIV_LINEAR,
    parameter int               SEL_W   = 4,
    parameter logic [SEL_W-1:0] RST_SEL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_next,
    output logic             stb,
    output logic [SEL_W-1:0] sel_cur
);

    localparam int unsigned MAX_R = max_ratio(MODE, SEL_W);
    localparam int          CNT_W = (MAX_R > 2) ? $clog2(MAX_R) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;

    // The decode of the terminal count depends on the encoding.
    generate
        if (MODE == DIV_LINEAR) begin : g_linear
            always_comb term = CNT_W'(int'(sel_cur) - 1);
        end else begin : g_pow2
            always_comb term = CNT_W'(div_ratio(DIV_POW2, int'(sel_cur)) - 1);
        end
    endgenerate

    assign stb = (cnt == term);

    // A new select is loaded only at the edge that ends the current period.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sel_cur <= RST_SEL;
        end else if (stb) begin
            cnt     <= '0;
            sel_cur <= sel_next;
        end else begin
            cnt     <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ratio_regs.sv
module ratio_regs
    import ratio_pkg::*;
#(
    parameter int                SYS_W    = 4,
    parameter int                CORE_W   = 2,
    parameter int                DATA_W   = 8,
    parameter logic [SYS_W-1:0]  SYS_RST  = 4'd5,
    parameter logic [CORE_W-1:0] CORE_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SYS_W-1:0]  sys_next,
    output logic [CORE_W-1:0] core_next,
    output ctrl_state_t       ctrl
);

    logic [SYS_W-1:0]  sys_shadow;
    logic [CORE_W-1:0] core_shadow;
    logic [SYS_W-1:0]  wr_sys;
    logic [CORE_W-1:0] wr_core;
    logic              hit_ratio;
    logic              hit_ctrl;
    logic              sys_zero;
    logic              wdata_unused;

    assign wr_sys       = wdata[SYS_W-1:0];
    assign wr_core      = wdata[SYS_W +: CORE_W];
    assign hit_ratio    = wr && (reg_addr_e'(addr) == ADDR_RATIO);
    assign hit_ctrl     = wr && (reg_addr_e'(addr) == ADDR_CTRL);
    assign sys_zero     = hit_ratio && (wr_sys == '0);
    assign wdata_unused = ^wdata[DATA_W-1:1];

    // A write in this cycle is visible to a divider that ends its period now.
    always_comb begin
        sys_next  = (hit_ratio && !sys_zero) ? wr_sys  : sys_shadow;
        core_next = hit_ratio                ? wr_core : core_shadow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_shadow  <= SYS_RST;
            core_shadow <= CORE_RST;
            ctrl.out_en <= 1'b1;
            ctrl.err    <= 1'b0;
        end else begin
            sys_shadow  <= sys_next;
            core_shadow <= core_next;
            if (hit_ctrl) begin
                ctrl.out_en <= wdata[0];
            end
            if (sys_zero) begin
                ctrl.err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic stb,
    output logic out
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            out <= 1'b0;
        end else if (stb) begin
            out <= ~out;
        end
    end

endmodule

// File: rtl/ratio_strobe_gen.sv
module ratio_strobe_gen
    import ratio_pkg::*;
#(
    parameter int                SYS_W    = SYS_SEL_W,
    parameter int                CORE_W   = CORE_SEL_W,
    parameter int                DATA_W   = REG_DATA_W,
    parameter logic [SYS_W-1:0]  SYS_RST  = 4'd5,
    parameter logic [CORE_W-1:0] CORE_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_stb,
    output logic              core_stb,
    output logic              clkout,
    output logic              cfg_err
);

    logic [SYS_W-1:0]  sys_next;
    logic [SYS_W-1:0]  sys_cur;
    logic [CORE_W-1:0] core_next;
    logic [CORE_W-1:0] core_cur;
    ctrl_state_t       ctrl;
    logic              clk_en;

    ratio_regs #(
        .SYS_W    (SYS_W),
        .CORE_W   (CORE_W),
        .DATA_W   (DATA_W),
        .SYS_RST  (SYS_RST),
        .CORE_RST (CORE_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .sys_next  (sys_next),
        .core_next (core_next),
        .ctrl      (ctrl)
    );

    ratio_counter #(
        .MODE    (DIV_LINEAR),
        .SEL_W   (SYS_W),
        .RST_SEL (SYS_RST)
    ) u_sys_div (
        .clk      (clk),
        .rst      (rst),
        .sel_next (sys_next),
        .stb      (sys_stb),
        .sel_cur  (sys_cur)
    );

    ratio_counter #(
        .MODE    (DIV_POW2),
        .SEL_W   (CORE_W),
        .RST_SEL (CORE_RST)
    ) u_core_div (
        .clk      (clk),
        .rst      (rst),
        .sel_next (core_next),
        .stb      (core_stb),
        .sel_cur  (core_cur)
    );

    assign clk_en  = ctrl.out_en;
    assign cfg_err = ctrl.err;

    clkout_gen u_clkout (
        .clk (clk),
        .rst (rst),
        .en  (clk_en),
        .stb (sys_stb),
        .out (clkout)
    );

    always_comb begin
        if (reg_addr_e'(reg_addr) == ADDR_RATIO) begin
            reg_rdata = DATA_W'({core_cur, sys_cur});
        end else begin
            reg_rdata = DATA_W'({ctrl.err, ctrl.out_en});
        end
    end

endmodule

// File: rtl/ratio_checker.sv
module ratio_checker #(
    parameter int SYS_W  = 4,
    parameter int CORE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [SYS_W-1:0]  wr_sys_field,
    input logic              sys_stb,
    input logic              core_stb,
    input logic              clkout,
    input logic              clk_en,
    input logic              cfg_err,
    input logic [SYS_W-1:0]  sys_cur,
    input logic [CORE_W-1:0] core_cur
);

    p_zero_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && wr_sys_field == '0) |=> cfg_err);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    p_sys_no_runt_r4: assert property (@(posedge clk) disable iff (rst)
        sys_stb |=> (!sys_stb || sys_cur == SYS_W'(1)));

    p_core_no_runt_r3: assert property (@(posedge clk) disable iff (rst)
        core_stb |=> (!core_stb || core_cur == '0));

    p_clkout_off_r7: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> !clkout);

    p_clkout_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !sys_stb) |=> $stable(clkout));

endmodule

bind ratio_strobe_gen ratio_checker #(
    .SYS_W  (SYS_W),
    .CORE_W (CORE_W)
) u_ratio_checker (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .wr_sys_field (reg_wdata[SYS_W-1:0]),
    .sys_stb      (sys_stb),
    .core_stb     (core_stb),
    .clkout       (clkout),
    .clk_en       (clk_en),
    .cfg_err      (cfg_err),
    .sys_cur      (sys_cur),
    .core_cur     (core_cur)
);

// File: tb/ratio_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module ratio_strobe_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sys_stb;
    logic       core_stb;
    logic       clkout;
    logic       cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ratio_strobe_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sys_stb   (sys_stb),
        .core_stb  (core_stb),
        .clkout    (clkout),
        .cfg_err   (cfg_err)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(bit a, logic [7:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic read_reg(bit a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    function automatic bit pick(bit core);
        return core ? core_stb : sys_stb;
    endfunction

    // Waits for a strobe, then counts fast cycles to the next one.
    // With do_wr set, a ratio write is issued two cycles into that period.
    task automatic gap(bit core, bit do_wr, logic [7:0] d, output int g);
        int guard = 0;
        @(negedge clk);
        while (!pick(core) && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        g = 0;
        do begin
            @(negedge clk);
            g++;
            if (do_wr && g == 2) begin
                reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = d;
            end else begin
                reg_wr = 1'b0;
            end
        end while (!pick(core) && g < 100);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        int g;
        pulse_reset();
        check("R1 core_stb after reset", int'(core_stb), 1);
        check("R1 sys_stb after reset", int'(sys_stb), 0);
        check("R1 cfg_err after reset", int'(cfg_err), 0);
        check("R1 clkout after reset", int'(clkout), 0);
        read_reg(1'b0, v);
        check("R1 R5 ratio readback after reset", v, 8'h05);
        read_reg(1'b1, v);
        check("R1 R8 control readback after reset", v, 8'h01);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!sys_stb && g < 50);
        check("R1 first system strobe delay", g, 4);
    endtask

    task automatic t_sys_ratios();
        int g;
        int v;
        int ratios[4] = '{1, 2, 7, 15};
        foreach (ratios[i]) begin
            do_write(1'b0, 8'(ratios[i]));
            gap(1'b0, 1'b0, 8'h0, g);
            gap(1'b0, 1'b0, 8'h0, g);
            check("R2 system period", g, ratios[i]);
            read_reg(1'b0, v);
            check("R5 system select readback", v & 8'h0F, ratios[i]);
        end
    endtask

    task automatic t_core_ratios();
        int g;
        int v;
        for (int s = 0; s < 4; s++) begin
            do_write(1'b0, 8'((s << 4) | 5));
            gap(1'b1, 1'b0, 8'h0, g);
            gap(1'b1, 1'b0, 8'h0, g);
            check("R3 core period", g, 1 << s);
            read_reg(1'b0, v);
            check("R5 core select readback", (v >> 4) & 3, s);
        end
    endtask

    task automatic t_boundary();
        int g;
        do_write(1'b0, 8'h05);
        gap(1'b0, 1'b0, 8'h0, g);
        gap(1'b0, 1'b1, 8'h03, g);
        check("R4 system period in progress keeps old ratio", g, 5);
        gap(1'b0, 1'b0, 8'h0, g);
        check("R4 system new ratio on next period", g, 3);
        do_write(1'b0, 8'h33);
        gap(1'b1, 1'b0, 8'h0, g);
        gap(1'b1, 1'b1, 8'h13, g);
        check("R4 core period in progress keeps old ratio", g, 8);
        gap(1'b1, 1'b0, 8'h0, g);
        check("R4 core new ratio on next period", g, 2);
    endtask

    task automatic t_zero_select();
        int g;
        int v;
        do_write(1'b0, 8'h20);
        check("R6 error flag after zero select", int'(cfg_err), 1);
        gap(1'b0, 1'b0, 8'h0, g);
        gap(1'b0, 1'b0, 8'h0, g);
        check("R6 system period unchanged", g, 3);
        gap(1'b1, 1'b0, 8'h0, g);
        gap(1'b1, 1'b0, 8'h0, g);
        check("R6 core field still accepted", g, 4);
        read_reg(1'b0, v);
        check("R6 ratio readback", v, 8'h23);
        read_reg(1'b1, v);
        check("R8 control readback with error", v, 8'h03);
    endtask

    task automatic t_clkout();
        int hi;
        int lo;
        int highs;
        int v;
        int guard;
        guard = 0;
        @(negedge clk);
        while (clkout && guard < 100) begin @(negedge clk); guard++; end
        while (!clkout && guard < 200) begin @(negedge clk); guard++; end
        hi = 0;
        while (clkout && hi < 100) begin hi++; @(negedge clk); end
        lo = 0;
        while (!clkout && lo < 100) begin lo++; @(negedge clk); end
        check("R7 clkout high run", hi, 3);
        check("R7 clkout low run", lo, 3);
        do_write(1'b1, 8'h00);
        read_reg(1'b1, v);
        check("R8 R9 control readback when disabled", v, 8'h02);
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clkout) highs++;
        end
        check("R7 clkout held low when disabled", highs, 0);
        do_write(1'b1, 8'h01);
        read_reg(1'b1, v);
        check("R9 error kept after control write", v, 8'h03);
        highs = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (clkout) highs++;
        end
        check("R7 clkout active again", int'(highs > 0), 1);
        pulse_reset();
        check("R9 error cleared by reset", int'(cfg_err), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_sys_ratios();
        t_core_ratios();
        t_boundary();
        t_zero_select();
        t_clkout();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule